// File: doc/BRIEF.md
# ADC Serial Result Readout Port

This block is the slave side of the serial read path of a multichannel converter. An external controller owns the serial clock and an active-low frame strobe. On each read frame the port sends a 16-bit word, most significant bit first. The word is a zero bit, then the three channel-address bits from the control register, then the 12-bit conversion result. The port drives a data line and a separate output-enable, which together stand for a three-state pin.

The external clock and strobe are not related to the system clock. Each one passes through a two-flop synchronizer, and edge detection works on the synchronized samples. The system clock must run at least eight times faster than the serial clock. The data line changes on serial-clock rising edges, so the receiver can sample it on falling edges. The leading zero is placed according to where the strobe falls within the clock phase, so that it is valid on the first falling edge after the strobe falls. The serial clock may stop and restart within a frame.

The converter supplies a one-cycle done pulse together with its result. While a read is in progress, the result register is not updated. The newest result is held aside and applied when the strobe returns high.

Top module: `adc_readout_port`

## Requirements
- R1: A frame sends the 16-bit word {1'b0, chan_addr[2:0], result[11:0]}, bit 15 first, one bit per serial-clock period. The channel address is sampled when the strobe falls.
- R2: After reset `sdo_oe` is 0 and the result register is 0. While `sdo_oe` is 1, `sdo` changes only after a rising edge of `sclk_in` and never around a falling edge.
- R3: If `frame_n_in` falls while `sclk_in` is high, `sdo_oe` goes to 1 and `sdo` shows 0 before the next falling edge of `sclk_in`.
- R4: If `frame_n_in` falls while `sclk_in` is low, `sdo_oe` stays 0 until the next rising edge of `sclk_in`, which drives the leading zero.
- R5: The serial clock may pause, held low, at any point in a frame while the strobe stays low. The remaining bits then continue without loss or repetition.
- R6: After all 16 bits have been sent, `sdo_oe` returns to 0 on the first rising edge of either `sclk_in` or `frame_n_in`.
- R7: A `conv_done` pulse while the strobe is low does not change the word being sent. The result register changes only while the strobe is high.
- R8: If the strobe rises before bit 16, the frame is aborted: `sdo_oe` goes to 0 and any held result is applied.
- R9: Only one result is held during a read. A later `conv_done` in the same read replaces the earlier one.
- R10: A `conv_done` pulse while the strobe is high updates the result register at once, and the next frame carries that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the external controller |
| frame_n_in | input | 1 | Active-low read frame strobe |
| chan_addr | input | 3 | Channel address bits from the control register |
| conv_done | input | 1 | One-cycle pulse: a new conversion result is valid |
| conv_result | input | 12 | Conversion result accompanying `conv_done` |
| sdo | output | 1 | Serial data, valid while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable; 0 means the data pin is high impedance |

## Verification
The main frame is read for all eight channel addresses. Each address is read with the strobe falling in the high phase of the clock and again in the low phase, which shows whether the leading zero is timed correctly in each case. The results are arithmetic patterns, and their bits differ between frames, so a shift, a duplicated bit or a dropped bit shows up in the received word. Some frames pause the clock halfway through, and some end on a strobe rise rather than a clock rise, which separates the burst handling from the two release paths. Separate frames take one or two conversions in mid-read, or are aborted after a few bits. These show whether a result is deferred, whether the newest held value replaces the older one, and whether an aborted frame still applies the held value.

// File: rtl/readout_pkg.sv
package readout_pkg;
  // Synchronized view of one external signal.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_ev_t;

  localparam int DEF_ADDR_W = 3;
  localparam int DEF_RES_W  = 12;
  localparam int DEF_SYNC   = 2;
endpackage

// File: rtl/edge_sync.sv
module edge_sync
  import readout_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     async_in,
  output edge_ev_t ev
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign ev.level = chain[STAGES-1];
  assign ev.rise  = chain[STAGES-1] & ~prev;
  assign ev.fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/result_holder.sv
module result_holder #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             read_end,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic [RES_W-1:0] out_reg
);
  logic             pend_vld;
  logic [RES_W-1:0] pend_val;

  // Named events for the checks below.
  wire defer_ev = conv_done & busy;
  wire apply_ev = read_end & pend_vld & ~conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_reg  <= '0;
      pend_vld <= 1'b0;
      pend_val <= '0;
    end else if (conv_done) begin
      if (busy) begin
        pend_vld <= 1'b1;
        pend_val <= conv_result;
      end else begin
        out_reg  <= conv_result;
        pend_vld <= 1'b0;
      end
    end else if (apply_ev) begin
      out_reg  <= pend_val;
      pend_vld <= 1'b0;
    end
  end

  // R7
  out_frozen_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_reg) |-> $past(!busy));

  // R9
  held_value_tracks_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    defer_ev |=> (pend_vld && pend_val == $past(conv_result)));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import readout_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  edge_ev_t          sclk_ev,
  input  edge_ev_t          strb_ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [RES_W-1:0]  result,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int FRAME_W = 1 + ADDR_W + RES_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [ADDR_W-1:0] a, input logic [RES_W-1:0] r);
    return {1'b0, a, r};
  endfunction

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   sent;
  logic               active;
  logic               oe_q;

  // Named events.
  wire frame_fall = strb_ev.fall;
  wire frame_rise = strb_ev.rise;
  wire lead_now   = frame_fall & sclk_ev.level;
  wire step_ev    = active & sclk_ev.rise & ~frame_rise & ~frame_fall;
  wire first_ev   = step_ev & (sent == '0);
  wire adv_ev     = step_ev & (sent != '0) & (sent != LAST);
  wire done_rel   = step_ev & (sent == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sent   <= '0;
      active <= 1'b0;
      oe_q   <= 1'b0;
    end else if (frame_rise) begin
      active <= 1'b0;
      oe_q   <= 1'b0;
      sent   <= '0;
    end else if (frame_fall) begin
      shreg  <= pack_frame(addr, result);
      active <= 1'b1;
      oe_q   <= lead_now;
      sent   <= lead_now ? CNT_W'(1) : '0;
    end else if (first_ev) begin
      oe_q <= 1'b1;
      sent <= CNT_W'(1);
    end else if (adv_ev) begin
      shreg <= shreg << 1;
      sent  <= sent + CNT_W'(1);
    end else if (done_rel) begin
      oe_q <= 1'b0;
    end
  end

  assign sdo_oe = oe_q;
  assign sdo    = oe_q & shreg[FRAME_W-1];

  // R1
  lead_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  // R3
  lead_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_now |=> (sdo_oe && !sdo));

  // R4
  lead_waits_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fall && !sclk_ev.level) |=> !sdo_oe);

  // R2
  data_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && sdo != $past(sdo)) |-> $past(sclk_ev.rise));

  // R2
  data_still_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_ev.fall && sdo_oe && $past(sdo_oe)) |-> $stable(sdo));

  // R6
  release_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> !sdo_oe);

  // R6
  release_on_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_rel |=> !sdo_oe);
endmodule

// File: rtl/adc_readout_port.sv
module adc_readout_port
  import readout_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int RES_W       = DEF_RES_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              frame_n_in,
  input  logic [ADDR_W-1:0] chan_addr,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int          N_IN  = 2;
  localparam logic [1:0]  RST_V = 2'b10; // index 0: clock idles low, 1: strobe idles high

  logic [N_IN-1:0] raw_in;
  edge_ev_t        ev [N_IN];
  logic [RES_W-1:0] held_result;

  assign raw_in = {frame_n_in, sclk_in};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_V[g])) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_in[g]),
      .ev       (ev[g])
    );
  end

  result_holder #(.RES_W(RES_W)) i_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (~ev[1].level),
    .read_end    (ev[1].rise),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .out_reg     (held_result)
  );

  frame_shifter #(.ADDR_W(ADDR_W), .RES_W(RES_W)) i_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_ev (ev[0]),
    .strb_ev (ev[1]),
    .addr    (chan_addr),
    .result  (held_result),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );
endmodule

// File: tb/test_adc_readout_port.sv
module test_adc_readout_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b0;
  logic frame_n_in = 1'b1;
  logic [2:0] chan_addr = '0;
  logic conv_done = 1'b0;
  logic [11:0] conv_result = '0;
  logic sdo, sdo_oe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  localparam int HP = 8; // system cycles per serial half period

  always #5 clk = ~clk;

  adc_readout_port i_adc_readout_port (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .frame_n_in(frame_n_in),
    .chan_addr(chan_addr), .conv_done(conv_done), .conv_result(conv_result),
    .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert(input logic [11:0] v);
    @(negedge clk);
    conv_result = v;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  function automatic logic [15:0] expect_word(input int a, input int r);
    return 16'(a * 4096 + r);
  endfunction

  // Reads one frame; mid_n conversions issued during bits 5 and 9.
  task automatic read_frame(input logic [2:0] a, input bit start_high, input bit burst,
                            input bit rel_strobe, input int mid_n,
                            input logic [11:0] v1, input logic [11:0] v2,
                            output logic [15:0] got);
    bit oe_ok = 1;
    chan_addr = a;
    sclk_in = start_high;
    wait_cyc(HP);
    frame_n_in = 1'b0;
    wait_cyc(HP);
    if (start_high)
      check(sdo_oe == 1'b1 && sdo == 1'b0, "R3 lead zero on strobe", {sdo_oe, sdo}, 2);
    else
      check(sdo_oe == 1'b0, "R4 held off until clock rise", sdo_oe, 0);
    for (int i = 0; i < 16; i++) begin
      if (i > 0 || !start_high) begin
        sclk_in = 1'b1;
        wait_cyc(HP);
      end
      got[15-i] = sdo;
      if (!sdo_oe) oe_ok = 0;
      sclk_in = 1'b0;
      if (i == 5 && mid_n >= 1) convert(v1);
      if (i == 9 && mid_n >= 2) convert(v2);
      wait_cyc(HP);
      if (burst && i == 7) wait_cyc(5 * HP);
    end
    check(oe_ok, "R1 enable held for 16 bits", oe_ok, 1);
    if (rel_strobe) begin
      frame_n_in = 1'b1;
      wait_cyc(HP);
      check(sdo_oe == 1'b0, "R6 release by strobe rise", sdo_oe, 0);
    end else begin
      sclk_in = 1'b1;
      wait_cyc(HP);
      check(sdo_oe == 1'b0, "R6 release by clock rise", sdo_oe, 0);
      sclk_in = 1'b0;
      frame_n_in = 1'b1;
    end
    wait_cyc(HP);
  endtask

  initial begin
    logic [15:0] got;
    logic [11:0] res, prev;
    wait_cyc(4);
    check(sdo_oe == 1'b0, "R2 reset enable low", sdo_oe, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    // Reset result is zero: first frame carries address only (R2).
    read_frame(3'd5, 1'b0, 1'b0, 1'b0, 0, 12'h0, 12'h0, got);
    check(got == expect_word(5, 0), "R2 reset result zero", got, expect_word(5, 0));

    // Sweep addresses and strobe phases (R1, R3, R4, R5, R10).
    for (int a = 0; a < 8; a++) begin
      for (int ph = 0; ph < 2; ph++) begin
        res = 12'((a * 16 + ph) * 1237 + 12'h5A3);
        convert(res);
        read_frame(3'(a), ph[0], a[0], (a == 3 || a == 6), 0, 12'h0, 12'h0, got);
        check(got == expect_word(a, int'(res)),
              a[0] ? "R5 burst frame word" : "R10 R1 frame word",
              got, expect_word(a, int'(res)));
      end
    end

    // Deferral during read (R7) then pending applied.
    prev = res;
    read_frame(3'd2, 1'b0, 1'b0, 1'b0, 1, 12'hABC, 12'h0, got);
    check(got == expect_word(2, int'(prev)), "R7 word unchanged during read",
          got, expect_word(2, int'(prev)));
    read_frame(3'd2, 1'b1, 1'b0, 1'b0, 0, 12'h0, 12'h0, got);
    check(got == expect_word(2, 12'hABC), "R7 deferred result applied",
          got, expect_word(2, 12'hABC));

    // Two conversions in one read: newest wins (R9).
    read_frame(3'd7, 1'b0, 1'b1, 1'b0, 2, 12'h123, 12'hF0F, got);
    check(got == expect_word(7, 12'hABC), "R9 word unchanged during read",
          got, expect_word(7, 12'hABC));
    read_frame(3'd7, 1'b0, 1'b0, 1'b1, 0, 12'h0, 12'h0, got);
    check(got == expect_word(7, 12'hF0F), "R9 newest held value",
          got, expect_word(7, 12'hF0F));

    // Abort after four bits (R8).
    chan_addr = 3'd1;
    sclk_in = 1'b0;
    wait_cyc(HP);
    frame_n_in = 1'b0;
    wait_cyc(HP);
    for (int i = 0; i < 4; i++) begin
      sclk_in = 1'b1; wait_cyc(HP);
      sclk_in = 1'b0; wait_cyc(HP);
    end
    convert(12'h3C6);
    wait_cyc(HP);
    check(sdo_oe == 1'b1, "R8 enable before abort", sdo_oe, 1);
    frame_n_in = 1'b1;
    wait_cyc(HP);
    check(sdo_oe == 1'b0, "R8 abort releases", sdo_oe, 0);
    read_frame(3'd1, 1'b1, 1'b0, 1'b0, 0, 12'h0, 12'h0, got);
    check(got == expect_word(1, 12'h3C6), "R8 held value applied on abort",
          got, expect_word(1, 12'h3C6));

    // Extremes of the result field (R1).
    convert(12'hFFF);
    read_frame(3'd0, 1'b0, 1'b0, 1'b0, 0, 12'h0, 12'h0, got);
    check(got == 16'h0FFF, "R1 all-ones result", got, 16'h0FFF);
    convert(12'h000);
    read_frame(3'd7, 1'b1, 1'b1, 1'b0, 0, 12'h0, 12'h0, got);
    check(got == 16'h7000, "R1 all-zero result", got, 16'h7000);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule